// File: doc/BRIEF.md
# Receive Queue Interrupt Controller

This block holds the bytes delivered by a serial receiver in a 128-entry queue and decides when software should be interrupted to collect them. A fill-level source fires once the queue holds at least a programmable number of bytes. This lets software collect data in large batches rather than one byte at a time. A stale-data source fires when bytes wait in the queue and no receive or read activity has happened for a programmable number of character times. This bounds the latency of short, irregular messages, such as request/response traffic where a silent line must be noticed.

An occupancy source can signal either "queue empty" or, when inverted, "queue holds at least one byte", for software that wants to react to any activity. An overrun source reports a byte that arrived while the queue was full. That byte is dropped, and only the newest stored entry carries an overrun mark, so earlier bytes read back clean. The current fill level and the oldest byte are always visible on the ports. Reading them has no side effects. The four sources are latched into status bits that clear on a read strobe, and the interrupt line is the OR of the enabled status bits.

Top module: `rxq_irq_ctrl`

## Requirements
- R1: `level` equals bytes accepted minus bytes removed and never exceeds 128. A pop while the queue is empty is ignored, and `level` stays 0.
- R2: Bytes leave the queue in arrival order. `rd_byte` always shows the oldest stored byte, and a pop removes it.
- R3: A push while the queue is full (and no pop in the same cycle) is dropped and `level` stays 128. Status bit 3 (overrun) is set, and only the newest stored entry reads back with `rd_ovr`=1. All earlier entries read back with `rd_ovr`=0.
- R4: Status bit 0 (level) is set on the clock edge after `level` >= `cfg_thresh`. With a threshold of 64 it is clear at 63 bytes and set at 64.
- R5: Status bit 1 (stale) is set on the edge of the N-th `char_tick` counted after the last push or pop, where N is `cfg_tmo_chars` and the queue is not empty. A push or pop restarts the count, and the bit fires at most once per quiet period. N=0 disables the source.
- R6: While the queue is empty, `char_tick` never sets status bit 1.
- R7: Status bit 2 (occupancy) is set on the edge after `level`==0 when `cfg_empty_inv`=0. When `cfg_empty_inv`=1 it is set on the edge after `level`!=0.
- R8: `stat_rd` clears all status bits at the next edge. A source whose set condition holds in that same cycle stays set.
- R9: `irq` is 1 exactly when some status bit is 1 and its bit in `cfg_irq_en` is 1. The bit positions are the same as for `status`: 0 level, 1 stale, 2 occupancy, 3 overrun.
- R10: Without `stat_rd` a status bit never clears, and reading `level` or `rd_byte` does not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the oldest byte |
| char_tick | input | 1 | One pulse per character time |
| stat_rd | input | 1 | Status read strobe; clears status |
| cfg_thresh | input | 8 | Fill-level threshold (64 typical) |
| cfg_tmo_chars | input | 8 | Quiet character times before stale fires (4 typical) |
| cfg_irq_en | input | 4 | Per-source interrupt enables |
| cfg_empty_inv | input | 1 | 0: occupancy source means empty; 1: means non-empty |
| rd_byte | output | 8 | Oldest stored byte |
| rd_ovr | output | 1 | Overrun mark of the oldest stored byte |
| level | output | 8 | Number of stored bytes, 0 to 128 |
| status | output | 4 | Latched sources: bit0 level, bit1 stale, bit2 occupancy, bit3 overrun |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that the fill count stays bounded and is unchanged by a pop on an empty queue or a push on a full one. They also check that a quiet counter restarts on activity, that a new stale flag always follows a character tick on a non-empty queue, that the occupancy flag follows the inverted source, that a read with nothing pending leaves status clear, and that disabled sources never drive the line. Other behaviours need the bench's scenarios: byte order and where the overrun mark lands across a full drain, the exact tick on which the stale flag appears and its restart after a mid-window pop or push, the threshold edge between 63 and 64 bytes, and status surviving idle cycles.

// File: rtl/rxq_irq_pkg.sv
package rxq_irq_pkg;
    localparam int unsigned FIFO_DEPTH = 128;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned TMO_W      = 8;
    localparam int unsigned NSRC       = 4;

    typedef enum int unsigned {
        SRC_LEVEL = 0,
        SRC_STALE = 1,
        SRC_OCC   = 2,
        SRC_OVRUN = 3
    } src_e;

    // packed bit order matches src_e positions
    typedef struct packed {
        logic ovrun;
        logic occ;
        logic stale;
        logic lvl;
    } src_t;

    function automatic logic any_enabled(input src_t s, input logic [NSRC-1:0] en);
        return |(s & en);
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 8,
    parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          dout_ovr,
    output logic [LW-1:0] fill,
    output logic          ovr_evt,
    output logic          activity
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] mark;
    logic [AW-1:0]    wptr, rptr, wptr_prev;
    logic [LW-1:0]    cnt;
    logic             full, empty, do_push, do_pop;

    assign full      = (cnt == FULL_CNT);
    assign empty     = (cnt == '0);
    assign do_pop    = pop && !empty;
    assign do_push   = push && (!full || do_pop);
    assign ovr_evt   = push && full && !do_pop;
    assign activity  = do_push || do_pop;
    assign wptr_prev = (wptr == '0) ? LAST_IDX : wptr - AW'(1);

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            mark <= '0;
        end else begin
            if (do_push) begin
                mark[wptr] <= 1'b0;
                wptr       <= (wptr == LAST_IDX) ? '0 : wptr + AW'(1);
            end
            if (ovr_evt) mark[wptr_prev] <= 1'b1;
            if (do_pop) rptr <= (rptr == LAST_IDX) ? '0 : rptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + LW'(1);
                2'b01:   cnt <= cnt - LW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout     = mem[rptr];
    assign dout_ovr = mark[rptr];
    assign fill     = cnt;

    // R1
    lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);
    // R1
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && cnt == '0) |=> (cnt == '0));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && full) |=> (cnt == FULL_CNT && $stable(wptr)));
endmodule

// File: rtl/rxq_stale_timer.sv
module rxq_stale_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          activity,
    input  logic          nonempty,
    input  logic [TW-1:0] limit,
    output logic          stale_evt
);
    logic [TW-1:0] cnt;
    logic          done;
    logic          counting;

    assign counting  = tick && nonempty && !activity && !done && (limit != '0);
    assign stale_evt = counting && (cnt >= limit - TW'(1));

    always_ff @(posedge clk) begin
        if (rst || activity || !nonempty) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (counting) begin
            if (stale_evt) done <= 1'b1;
            else           cnt  <= cnt + TW'(1);
        end
    end

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        activity |=> (cnt == '0 && !done));
endmodule

// File: rtl/rxq_irq_status.sv
module rxq_irq_status
    import rxq_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  src_t            set_v,
    input  logic            rd,
    input  logic [NSRC-1:0] en,
    output src_t            stat,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (rd ? src_t'('0) : stat) | set_v;
    end

    assign irq = any_enabled(stat, en);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && set_v == '0) |=> (stat == '0));
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);
endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl
    import rxq_irq_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned DW    = BYTE_W,
    parameter int unsigned TW    = TMO_W,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_push,
    input  logic [DW-1:0]   rx_byte,
    input  logic            rx_pop,
    input  logic            char_tick,
    input  logic            stat_rd,
    input  logic [LW-1:0]   cfg_thresh,
    input  logic [TW-1:0]   cfg_tmo_chars,
    input  logic [NSRC-1:0] cfg_irq_en,
    input  logic            cfg_empty_inv,
    output logic [DW-1:0]   rd_byte,
    output logic            rd_ovr,
    output logic [LW-1:0]   level,
    output logic [NSRC-1:0] status,
    output logic            irq
);
    logic [LW-1:0] fill;
    logic          ovr_evt, activity, stale_evt;
    src_t          set_v, stat;

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .LW(LW)) store_i (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte), .pop(rx_pop),
        .dout(rd_byte), .dout_ovr(rd_ovr), .fill(fill),
        .ovr_evt(ovr_evt), .activity(activity)
    );

    rxq_stale_timer #(.TW(TW)) timer_i (
        .clk(clk), .rst(rst), .tick(char_tick), .activity(activity),
        .nonempty(fill != '0), .limit(cfg_tmo_chars), .stale_evt(stale_evt)
    );

    always_comb begin
        set_v.lvl   = (fill >= cfg_thresh);
        set_v.stale = stale_evt;
        set_v.occ   = (fill == '0) ^ cfg_empty_inv;
        set_v.ovrun = ovr_evt;
    end

    rxq_irq_status status_i (
        .clk(clk), .rst(rst), .set_v(set_v), .rd(stat_rd),
        .en(cfg_irq_en), .stat(stat), .irq(irq)
    );

    assign level  = fill;
    assign status = stat;

    // R5 R6
    stale_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.stale) |-> ($past(char_tick) && $past(fill) != '0));
    // R7
    occ_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (fill != '0 && cfg_empty_inv) |=> stat.occ);
endmodule

// File: tb/rxq_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rxq_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_push = 0, rx_pop = 0, char_tick = 0, stat_rd = 0;
    logic [7:0] rx_byte = '0;
    logic [7:0] cfg_thresh = 8'd64, cfg_tmo_chars = 8'd4;
    logic [3:0] cfg_irq_en = 4'hF;
    logic       cfg_empty_inv = 1'b1;
    logic [7:0] rd_byte, level;
    logic       rd_ovr, irq;
    logic [3:0] status;

    int errors = 0, checks = 0;
    bit done_flag = 0;

    typedef struct { logic ovr; logic [7:0] d; } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    rxq_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .rx_push(rx_push), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .char_tick(char_tick), .stat_rd(stat_rd), .cfg_thresh(cfg_thresh),
        .cfg_tmo_chars(cfg_tmo_chars), .cfg_irq_en(cfg_irq_en),
        .cfg_empty_inv(cfg_empty_inv), .rd_byte(rd_byte), .rd_ovr(rd_ovr),
        .level(level), .status(status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock with the given inputs, returns at the following falling edge
    task automatic step(input bit p, input logic [7:0] b, input bit q, input bit t, input bit r);
        rx_push = p; rx_byte = b; rx_pop = q; char_tick = t; stat_rd = r;
        @(negedge clk);
        rx_push = 0; rx_pop = 0; char_tick = 0; stat_rd = 0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        if (sb.size() == 128) sb[sb.size()-1].ovr = 1'b1;
        else begin
            item_t it; it.ovr = 1'b0; it.d = b; sb.push_back(it);
        end
        step(1, b, 0, 0, 0);
    endtask

    task automatic pop_byte();
        step(0, 8'h00, 1, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1, 0);
    endtask

    // monitor: compares the departing byte against the scoreboard (R2, R3)
    always @(posedge clk) begin
        if (!rst && rx_pop && sb.size() != 0) begin
            item_t e;
            e = sb.pop_front();
            chk(rd_byte == e.d, "R2 byte order", rd_byte, e.d);
            chk(rd_ovr == e.ovr, "R3 overrun mark", rd_ovr, e.ovr);
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [3:0] snap;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(level == 0, "R1 reset level", level, 0);
        chk(status == 0, "R8 reset status", status, 0);
        chk(irq == 0, "R9 reset irq", irq, 0);

        push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
        chk(level == 3, "R1 level after 3 pushes", level, 3);
        step(0, 0, 0, 0, 0);
        chk(status == 4'b0100, "R7 inverted occupancy", status, 4'b0100);
        step(0, 0, 0, 0, 1);
        chk(status == 4'b0100, "R8 set wins over read", status, 4'b0100);
        cfg_empty_inv = 1'b0;
        step(0, 0, 0, 0, 0);
        chk(status == 4'b0100, "R10 no clear without read", status, 4'b0100);
        step(0, 0, 0, 0, 1);
        chk(status == 4'b0000, "R8 read clears", status, 0);

        ticks(3);
        chk(status[1] == 0, "R5 stale not after 3 ticks", status[1], 0);
        ticks(1);
        chk(status[1] == 1, "R5 stale at 4th tick", status[1], 1);
        cfg_irq_en = 4'b0010; #0.1;
        chk(irq == 1, "R9 stale enabled", irq, 1);
        cfg_irq_en = 4'b0001; #0.1;
        chk(irq == 0, "R9 stale masked", irq, 0);
        cfg_irq_en = 4'hF;
        step(0, 0, 0, 0, 1);
        ticks(2);
        chk(status[1] == 0, "R5 fires once per quiet period", status[1], 0);

        pop_byte();
        ticks(3);
        chk(status[1] == 0, "R5 pop restarts count", status[1], 0);
        push_byte(8'h44);
        ticks(3);
        chk(status[1] == 0, "R5 push restarts count", status[1], 0);
        ticks(1);
        chk(status[1] == 1, "R5 stale after restart", status[1], 1);

        while (sb.size() != 0) pop_byte();
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        chk(status == 4'b0100, "R7 empty occupancy", status, 4'b0100);
        ticks(6);
        chk(status[1] == 0, "R6 no stale when empty", status[1], 0);
        snap = status;
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
        chk(status == snap && level == 0, "R10 status stable while idle", status, snap);

        for (int i = 0; i < 63; i++) push_byte(8'(i + 8'h80));
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        chk(status[0] == 0, "R4 below threshold at 63", status[0], 0);
        push_byte(8'hC0);
        step(0, 0, 0, 0, 0);
        chk(status[0] == 1 && level == 64, "R4 threshold at 64", status[0], 1);

        for (int i = 0; i < 64; i++) push_byte(8'(i));
        chk(level == 128 && status[3] == 0, "R3 full without overrun", {status[3], level}, 128);
        push_byte(8'hEE); push_byte(8'hEF);
        chk(level == 128, "R3 level held at full", level, 128);
        chk(status[3] == 1, "R3 overrun status", status[3], 1);

        while (sb.size() != 0) pop_byte();
        chk(level == 0, "R1 drained", level, 0);
        pop_byte();
        chk(level == 0, "R1 pop on empty ignored", level, 0);

        finish_run();
    end
endmodule